// File: doc/BRIEF.md
# Prescaled Byte Timer with Match Restart

This block is an 8-bit up-counter that sits behind four byte-wide memory-mapped registers on a 20-bit peripheral bus. Software writes a control byte to start or stop the counter, to choose a mode and to pick a clock divider. The count can be loaded, a match value can be set, and a sticky event flag can be polled.

The divider turns the system clock into a count enable once every 1, 2, 3 or 4 clocks. In free-running mode the counter rolls over from 0xFF to 0x00 and raises the flag. In match mode the counter restarts at 0x00 on the enable that finds it equal to the match value, and that restart raises the flag. The flag reads as 0xFF when set and clears when it is read. Reads are combinational in the cycle that `bus_rd` is high. Writes take effect at the next clock edge.

Top module: `byte_timer`

## Requirements
- R1: After synchronous reset the count, match value, control byte and flag are all 0x00, and the divider phase starts from zero.
- R2: The control byte uses bit 0 as run (1 = counting) and bit 1 as mode (0 = free-running, 1 = match restart). Bits 3:2 are the divider code. Bits 7:4 are discarded on write and read back as zero.
- R3: While running with divider code c (00, 01, 10, 11), the count advances once every c+1 clocks. The first advance comes c+1 clocks after the edge that loaded the control byte.
- R4: In free-running mode, an advance from 0xFF gives 0x00 and sets the flag to 0xFF.
- R5: In match mode, an advance taken while the count equals the match value gives 0x00 and sets the flag to 0xFF. Passing 0xFF without a match wraps to 0x00 and leaves the flag alone.
- R6: With the run bit clear the count holds its value and the flag does not change, except through register accesses.
- R7: A write to the count (0xFFFF4) loads the written byte. It takes priority over an advance in the same cycle and restarts the divider phase from zero.
- R8: A read of the flag (0xFFFF7) returns its value and then clears it. If a flag-setting advance happens in the same cycle as the read, the flag stays 0xFF.
- R9: A control write that changes the divider code restarts the divider phase from zero, so the next advance comes c+1 clocks later.
- R10: Address map: count 0xFFFF4 read/write, match 0xFFFF5 write-only (reads 0x00), control 0xFFFF6 read/write, flag 0xFFFF7 read-only (writes ignored). Any other address reads 0x00 and ignores writes. `bus_rdata` is 0x00 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |

## Verification
The bench targets these cases:
- The 0xFF rollover in both modes. A design that flags in match mode on a plain wrap shows a spurious 0xFF flag.
- A match value of zero and of a value the count has already passed. A design that compares with greater-than, or compares after the increment, restarts at the wrong count.
- Flag reads that land on the exact cycle of a new event. A design that lets the clear win loses that event.
- Count loads and divider-code changes while counting, at every divider setting. A design that does not reset the phase advances one or more cycles early.
- Writes to the flag, reads of the write-only match register and accesses to unmapped addresses. A leaky decoder changes state or returns non-zero data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int unsigned ADDR_W = 20;
    parameter int unsigned DW     = 8;
    parameter int unsigned MAXDIV = 4;
    localparam int unsigned PH_W  = $clog2(MAXDIV);

    localparam logic [ADDR_W-1:0] A_COUNT = 20'hFFFF4;
    localparam logic [ADDR_W-1:0] A_MATCH = 20'hFFFF5;
    localparam logic [ADDR_W-1:0] A_CTRL  = 20'hFFFF6;
    localparam logic [ADDR_W-1:0] A_FLAG  = 20'hFFFF7;

    localparam logic [DW-1:0] FLAG_SET = {DW{1'b1}};
    localparam logic [DW-1:0] CNT_TOP  = {DW{1'b1}};

    typedef enum logic {MODE_FREE = 1'b0, MODE_MATCH = 1'b1} mode_e;

    typedef struct packed {
        logic [DW-5:0]   spare;
        logic [PH_W-1:0] div_code;
        mode_e           mode;
        logic            run;
    } ctrl_t;

    typedef struct packed {
        logic wr_count;
        logic wr_match;
        logic wr_ctrl;
        logic rd_flag;
    } dec_t;

    function automatic logic [PH_W-1:0] last_phase(input logic [PH_W-1:0] code);
        return code;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     count_q,
    input  logic [DW-1:0]     flag_q,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     match_q,
    output dec_t              dec,
    output logic              code_chg,
    output logic [DW-1:0]     rdata
);
    ctrl_t ctrl_in;

    always_comb begin
        dec.wr_count = wr && (addr == A_COUNT);
        dec.wr_match = wr && (addr == A_MATCH);
        dec.wr_ctrl  = wr && (addr == A_CTRL);
        dec.rd_flag  = rd && (addr == A_FLAG);
        ctrl_in          = ctrl_t'(wdata);
        ctrl_in.spare    = '0;
        code_chg         = dec.wr_ctrl && (ctrl_in.div_code != ctrl_q.div_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else begin
            if (dec.wr_ctrl)  ctrl_q  <= ctrl_in;
            if (dec.wr_match) match_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_COUNT: rdata = count_q;
                A_CTRL:  rdata = ctrl_q;
                A_FLAG:  rdata = flag_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PH_W-1:0] div_code,
    input  logic            restart,
    output logic            tick
);
    logic [PH_W-1:0] phase_q;
    logic            at_end;

    assign at_end = (phase_q == last_phase(div_code));
    assign tick   = run && at_end && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || !run || at_end) phase_q <= '0;
        else                                   phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  logic [DW-1:0] match_val,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          flag_rd,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] flag_q,
    output logic          evt
);
    logic hit;

    always_comb begin
        if (mode == MODE_MATCH) hit = (count_q == match_val);
        else                    hit = (count_q == CNT_TOP);
        evt = tick && !load && hit;
    end

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (load) count_q <= load_val;
        else if (evt)  count_q <= '0;
        else if (tick) count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= '0;
        else if (evt)     flag_q <= FLAG_SET;
        else if (flag_rd) flag_q <= '0;
    end
endmodule

// File: rtl/byte_timer.sv
module byte_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    ctrl_t         ctrl_q;
    dec_t          dec;
    logic [DW-1:0] match_q;
    logic [DW-1:0] count_q;
    logic [DW-1:0] flag_q;
    logic          code_chg;
    logic          tick;
    logic          evt;

    tmr_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .count_q(count_q), .flag_q(flag_q),
        .ctrl_q(ctrl_q), .match_q(match_q), .dec(dec),
        .code_chg(code_chg), .rdata(bus_rdata)
    );

    tmr_prescaler u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .div_code(ctrl_q.div_code),
        .restart(dec.wr_count || code_chg), .tick(tick)
    );

    tmr_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .mode(ctrl_q.mode),
        .match_val(match_q), .load(dec.wr_count), .load_val(bus_wdata),
        .flag_rd(dec.rd_flag), .count_q(count_q), .flag_q(flag_q), .evt(evt)
    );
endmodule

// File: rtl/byte_timer_chk.sv
module byte_timer_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input ctrl_t         ctrl_q,
    input dec_t          dec,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] count_q,
    input logic [DW-1:0] flag_q,
    input logic          evt
);
    AST_FLAG_ENCODING: assert property (@(posedge clk) disable iff (rst)
        (flag_q == '0) || (flag_q == FLAG_SET)); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        dec.wr_count |=> count_q == $past(bus_wdata)); // R7

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !dec.wr_count) |=> $stable(count_q)); // R6

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        evt |=> (flag_q == FLAG_SET) && (count_q == '0)); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_flag && !evt) |=> flag_q == '0); // R8

    AST_DIV1_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.div_code == '0 && ctrl_q.mode == MODE_FREE
         && !dec.wr_count && !dec.wr_ctrl) |=> count_q != $past(count_q)); // R3

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.spare == '0); // R2
endmodule

bind byte_timer byte_timer_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .dec(dec), .bus_wdata(bus_wdata),
    .count_q(count_q), .flag_q(flag_q), .evt(evt)
);

// File: tb/tb_byte_timer.sv
module tb_byte_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    int m_cnt, m_match, m_ctrl, m_flag, m_ph;

    always #4 clk = ~clk;

    byte_timer dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int expect_rd(input int a, input bit r);
        if (!r) return 0;
        case (a)
            'hFFFF4: return m_cnt;
            'hFFFF6: return m_ctrl;
            'hFFFF7: return m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic step(input int a, input bit w, input bit r, input int d);
        int exp_v, run, mode, code, n_ph, n_cnt, n_flag, n_ctrl, n_match;
        bit load, chg, tick, ev;
        bus_addr = a[19:0]; bus_wr = w; bus_rd = r; bus_wdata = d[7:0];
        #1;
        exp_v = expect_rd(a, r);
        checks++;
        if (bus_rdata !== exp_v[7:0]) begin
            errors++;
            $display("FAIL %s: addr %h rdata %h expected %h", req, a, bus_rdata, exp_v);
        end
        run  = m_ctrl & 1;
        mode = (m_ctrl >> 1) & 1;
        code = (m_ctrl >> 2) & 3;
        load = w && a == 'hFFFF4;
        chg  = w && a == 'hFFFF6 && (((d >> 2) & 3) != code);
        tick = run && m_ph == code && !load && !chg;
        ev   = tick && (mode ? (m_cnt == m_match) : (m_cnt == 255));
        n_ph = (load || chg || !run || m_ph == code) ? 0 : m_ph + 1;
        n_cnt = load ? (d & 255) : ev ? 0 : tick ? ((m_cnt + 1) % 256) : m_cnt;
        n_flag = ev ? 255 : (r && a == 'hFFFF7) ? 0 : m_flag;
        n_ctrl = (w && a == 'hFFFF6) ? (d & 15) : m_ctrl;
        n_match = (w && a == 'hFFFF5) ? (d & 255) : m_match;
        @(posedge clk);
        m_ph = n_ph; m_cnt = n_cnt; m_flag = n_flag; m_ctrl = n_ctrl; m_match = n_match;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d); step(a, 1, 0, d); endtask
    task automatic rd(input int a); step(a, 0, 1, 0); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('hFFFF4, 0, 1, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_cnt = 0; m_match = 0; m_ctrl = 0; m_flag = 0; m_ph = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        req = "R1"; rd('hFFFF4); rd('hFFFF6); rd('hFFFF7); idle(3);
        req = "R2"; wr('hFFFF6, 'hF0); rd('hFFFF6); wr('hFFFF6, 'hA2); rd('hFFFF6);
        wr('hFFFF6, 'h00);
        req = "R4"; wr('hFFFF4, 250); wr('hFFFF6, 'h01); idle(8);
        req = "R8"; rd('hFFFF7); rd('hFFFF7);
        req = "R3"; wr('hFFFF6, 'h05); idle(12); wr('hFFFF6, 'h09); idle(14);
        wr('hFFFF6, 'h0D); idle(16);
        req = "R9"; idle(2); wr('hFFFF6, 'h05); idle(5); wr('hFFFF6, 'h0D); idle(1);
        wr('hFFFF6, 'h09); idle(6); wr('hFFFF6, 'h09); idle(4);
        req = "R7"; wr('hFFFF4, 40); idle(2); wr('hFFFF4, 100); idle(1);
        wr('hFFFF6, 'h01); idle(2); wr('hFFFF4, 7); wr('hFFFF4, 9); idle(3);
        req = "R5"; wr('hFFFF5, 5); wr('hFFFF4, 0); wr('hFFFF6, 'h03); idle(20);
        rd('hFFFF7); wr('hFFFF5, 0); idle(6); rd('hFFFF7);
        wr('hFFFF5, 10); wr('hFFFF4, 200); idle(70); rd('hFFFF7); idle(4);
        req = "R8"; wr('hFFFF5, 2); wr('hFFFF4, 0);
        for (int i = 0; i < 12; i++) rd('hFFFF7);
        wr('hFFFF6, 'h07);
        for (int i = 0; i < 14; i++) rd('hFFFF7);
        req = "R6"; wr('hFFFF6, 'h00); idle(10); rd('hFFFF7); wr('hFFFF4, 255); idle(6);
        rd('hFFFF7);
        req = "R10"; wr('hFFFF7, 'hFF); rd('hFFFF7); rd('hFFFF5);
        wr('hFFFF8, 'h33); wr('hFFFF3, 'h01); rd('hFFFF8); rd('h00004);
        step('hFFFF4, 0, 0, 0); rd('hFFFF6); idle(2);
        req = "R1"; rst = 1'b1; step('hFFFF4, 0, 0, 0);
        m_cnt = 0; m_match = 0; m_ctrl = 0; m_flag = 0; m_ph = 0;
        rst = 1'b0; rd('hFFFF4); rd('hFFFF6); rd('hFFFF7);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule